// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block lets software take an SDRAM through its power-up initialization one command at a time. Software uses a 32-bit control register to enable the controller and to arm one of three commands: precharge-all, auto-refresh or mode-register-set. It then performs a write into the SDRAM address window. The block turns that write into exactly one command on the SDRAM control pins. The write is held until the minimum gap that the device needs after that command has passed. The order of commands is set entirely by software, so any sequence the device asks for can be produced.

For a mode-register-set, the data of the window write is not used. The mode value is taken from the write's address bits instead. The CAS latency encoded in that address is compared against a separate 2-bit CAS-latency setting, and any difference is flagged. A sticky "initialized" flag in the control register tells software when a mode-register-set has completed, which means normal accesses may start.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, the register reads 0, `sd_clk_en` and `win_ready` are 0, and the command pins show NOP (CS#/RAS#/CAS#/WE# = 0111) with `sd_addr` and `sd_ba` at 0.
- R2: Control register layout is as follows. Bit 4 is enable. Bits 2, 1 and 0 arm MRS, PALL and REF respectively. These four bits are read/write. Bit 3 is the initialized flag and is read-only, so a write to it has no effect. Bits 31:5 read as 0.
- R3: `sd_clk_en` equals the enable bit, and no command is driven unless enable was set when the write was accepted.
- R4: A write that is accepted with a command armed drives that command for exactly one cycle, starting the cycle after acceptance. The encodings on CS#/RAS#/CAS#/WE# are PALL = 0010 with `sd_addr` = 0x400 (only address bit 10 high), REF = 0001 with address 0, and MRS = 0000. Every other cycle shows NOP = 0111.
- R5: For MRS, `sd_addr` = `win_addr[13:1]` and `sd_ba` = `win_addr[15:14]`. For example, offset 0x442 gives `sd_addr` 0x221 and bank 0.
- R6: When several arm bits are set, a single write issues only one command, chosen with priority MRS > PALL > REF.
- R7: The arm bit of an issued command clears itself, so a further window write issues nothing unless that command is armed again.
- R8: `win_ready` is a one-cycle pulse. It rises T_RP, T_RFC or T_MRD cycles after the command cycle begins, for PALL, REF or MRS respectively.
- R9: The initialized flag is 1 by the cycle in which an MRS write's `win_ready` is high. It then stays 1 until reset.
- R10: `cl_err` is updated on each MRS. It is set to 1 when `sd_addr[6:4]` differs from {0, `cas_cfg`}, and to 0 otherwise.
- R11: A window write that is accepted with enable 0 or with no arm bit set issues no command. It gets `win_ready` in the cycle after the request, and it leaves the arm bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read value |
| cas_cfg | input | 2 | Configured CAS latency |
| win_req | input | 1 | Write to SDRAM window, held until `win_ready` |
| win_addr | input | 16 | Byte offset of the window write |
| win_ready | output | 1 | Window write completion pulse |
| sd_clk_en | output | 1 | SDRAM clock running |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | 13 | SDRAM address pins |
| sd_ba | output | 2 | SDRAM bank address |
| cl_err | output | 1 | CAS latency mismatch on last MRS |

## Verification
The bench builds the block with its defaults: T_RP = 3, T_RFC = 7 and T_MRD = 2, with a 13-bit row and 2 bank bits. Because the three gaps are short and all different, each command's `win_ready` latency is a distinct cycle count (4, 8 and 3 cycles after the request, against 1 for a dropped write). A wrong gap table or a swapped command therefore shows up as a specific latency. The full 16-bit offset fits the window, so both bank bits and the CAS-latency field can be driven to nonzero values.

// File: rtl/sdram_init_pkg.sv
// Shared definitions for the SDRAM power-up sequencer.
// Assumes an active-low command bus ordered {CS#, RAS#, CAS#, WE#}.
package sdram_init_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } init_cmd_e;

    localparam logic [3:0] PIN_NOP  = 4'b0111;
    localparam logic [3:0] PIN_PALL = 4'b0010;
    localparam logic [3:0] PIN_REF  = 4'b0001;
    localparam logic [3:0] PIN_MRS  = 4'b0000;

    localparam int PALL_ADDR_BIT = 10;   // all-banks select during precharge
    localparam int CL_FIELD_LSB  = 4;    // CAS latency field in the mode word
    localparam int CL_FIELD_W    = 3;
endpackage

// File: rtl/sdram_init_regs.sv
// Control register: enable bit, three arm bits and the sticky initialized flag.
// Assumes that a software write and a hardware arm-clear in the same cycle
// resolve in favour of the software write.
module sdram_init_regs #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [2:0]       clr_arm,
    input  logic             set_init,
    output logic [REG_W-1:0] reg_rdata,
    output logic             ctl_en,
    output logic [2:0]       arm,
    output logic             init_done
);
    localparam int EN_BIT   = 4;
    localparam int FLAG_BIT = 3;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[REG_W-1:EN_BIT+1], reg_wdata[FLAG_BIT]};

    // Register update: software write, arm self-clear, sticky flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            arm       <= 3'b000;
            init_done <= 1'b0;
        end else begin
            if (set_init) init_done <= 1'b1;
            if (reg_wr) begin
                ctl_en <= reg_wdata[EN_BIT];
                arm    <= reg_wdata[2:0];
            end else begin
                arm <= arm & ~clr_arm;
            end
        end
    end

    // Read view with reserved bits zero.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[EN_BIT]   = ctl_en;
        reg_rdata[FLAG_BIT] = init_done;
        reg_rdata[2:0]      = arm;
    end

    // R9
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));
endmodule

// File: rtl/sdram_init_fsm.sv
// Accepts window writes, picks one armed command by priority and holds the
// write until the command's minimum gap has passed. Assumes every gap >= 1
// and that the requester keeps win_req high until win_ready.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RFC = 7,
    parameter int T_MRD = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_en,
    input  logic [2:0] arm,
    input  logic      win_req,
    output logic      win_ready,
    output init_cmd_e issue_cmd,
    output logic [2:0] clr_arm,
    output logic      set_init
);
    localparam int GAP_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                            : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
    localparam int CNT_W = $clog2(GAP_MAX + 1);

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} state_e;

    state_e     state;
    logic [CNT_W-1:0] cnt;
    init_cmd_e  cur;
    init_cmd_e  sel;

    function automatic logic [CNT_W-1:0] gap_load(init_cmd_e c);
        case (c)
            CMD_PALL: return CNT_W'(T_RP - 1);
            CMD_REF:  return CNT_W'(T_RFC - 1);
            default:  return CNT_W'(T_MRD - 1);
        endcase
    endfunction

    // Priority pick among armed commands; nothing when disabled.
    always_comb begin
        if (!ctl_en)     sel = CMD_NONE;
        else if (arm[2]) sel = CMD_MRS;
        else if (arm[1]) sel = CMD_PALL;
        else if (arm[0]) sel = CMD_REF;
        else             sel = CMD_NONE;
    end

    assign issue_cmd = (state == S_IDLE && win_req) ? sel : CMD_NONE;

    // One-hot clear of the arm bit that was just used.
    always_comb begin
        case (issue_cmd)
            CMD_MRS:  clr_arm = 3'b100;
            CMD_PALL: clr_arm = 3'b010;
            CMD_REF:  clr_arm = 3'b001;
            default:  clr_arm = 3'b000;
        endcase
    end

    assign set_init  = (state == S_WAIT) && (cnt == '0) && (cur == CMD_MRS);
    assign win_ready = (state == S_DONE);

    // Sequencer state and gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            cur   <= CMD_NONE;
        end else begin
            case (state)
                S_IDLE: if (win_req) begin
                    cur <= sel;
                    if (sel == CMD_NONE) state <= S_DONE;
                    else begin
                        state <= S_WAIT;
                        cnt   <= gap_load(sel);
                    end
                end
                S_WAIT: if (cnt == '0) state <= S_DONE;
                        else           cnt   <= cnt - 1'b1;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |=> !win_ready);
endmodule

// File: rtl/sdram_init_pins.sv
// Registers the SDRAM command, address and bank pins and the CAS mismatch
// bit. Assumes the window offset's bit 0 is a byte lane and not used.
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int BA_W  = 2,
    localparam int ADDR_W = ROW_W + BA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_cmd_e         issue_cmd,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [1:0]        cas_cfg,
    output logic [3:0]        cmd_pins,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              cl_err
);
    logic unused_a0;
    assign unused_a0 = win_addr[0];

    logic [ROW_W-1:0]      mode_word;
    logic [CL_FIELD_W-1:0] mode_cl;
    assign mode_word = win_addr[ROW_W:1];
    assign mode_cl   = mode_word[CL_FIELD_LSB +: CL_FIELD_W];

    // Drive one command cycle per issue, NOP otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pins <= PIN_NOP;
            sd_addr  <= '0;
            sd_ba    <= '0;
            cl_err   <= 1'b0;
        end else begin
            cmd_pins <= PIN_NOP;
            sd_addr  <= '0;
            sd_ba    <= '0;
            case (issue_cmd)
                CMD_PALL: begin
                    cmd_pins               <= PIN_PALL;
                    sd_addr[PALL_ADDR_BIT] <= 1'b1;
                end
                CMD_REF: cmd_pins <= PIN_REF;
                CMD_MRS: begin
                    cmd_pins <= PIN_MRS;
                    sd_addr  <= mode_word;
                    sd_ba    <= win_addr[ADDR_W-1 -: BA_W];
                    cl_err   <= (mode_cl != {1'b0, cas_cfg});
                end
                default: ;
            endcase
        end
    end

    // R4
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins != PIN_NOP) |=> (cmd_pins == PIN_NOP));
    // R5
    mrs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == PIN_MRS) |-> (sd_addr == $past(win_addr[ROW_W:1])));
endmodule

// File: rtl/sdram_init_seq.sv
// Top of the SDRAM power-up sequencer: control register, sequencer and pin
// stage. Assumes one window write outstanding at a time.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ROW_W = 13,
    parameter int BA_W  = 2,
    parameter int T_RP  = 3,
    parameter int T_RFC = 7,
    parameter int T_MRD = 2,
    localparam int ADDR_W = ROW_W + BA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [1:0]        cas_cfg,
    input  logic              win_req,
    input  logic [ADDR_W-1:0] win_addr,
    output logic              win_ready,
    output logic              sd_clk_en,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              cl_err
);
    logic       ctl_en, init_done, set_init;
    logic [2:0] arm, clr_arm;
    logic [3:0] cmd_pins;
    init_cmd_e  issue_cmd;

    sdram_init_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .clr_arm(clr_arm), .set_init(set_init), .reg_rdata(reg_rdata),
        .ctl_en(ctl_en), .arm(arm), .init_done(init_done)
    );

    sdram_init_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .arm(arm),
        .win_req(win_req), .win_ready(win_ready), .issue_cmd(issue_cmd),
        .clr_arm(clr_arm), .set_init(set_init)
    );

    sdram_init_pins #(.ROW_W(ROW_W), .BA_W(BA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .issue_cmd(issue_cmd), .win_addr(win_addr),
        .cas_cfg(cas_cfg), .cmd_pins(cmd_pins), .sd_addr(sd_addr),
        .sd_ba(sd_ba), .cl_err(cl_err)
    );

    assign sd_clk_en = ctl_en;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;

    // R7
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cmd == CMD_MRS && !reg_wr) |=> !arm[2]);
    // R3
    cmd_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins != PIN_NOP) |-> $past(ctl_en));
endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  cas_cfg = 2'd2;
    logic        win_req = 1'b0;
    logic [15:0] win_addr = '0;
    logic        win_ready, sd_clk_en, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic        cl_err;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_init_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cas_cfg(cas_cfg), .win_req(win_req),
        .win_addr(win_addr), .win_ready(win_ready), .sd_clk_en(sd_clk_en),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .cl_err(cl_err)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Window write; checks pins one cycle later and ready latency.
    task automatic win_write(input logic [15:0] a, input logic [3:0] ep,
                             input logic [12:0] ea, input logic [1:0] eb,
                             input int elat, input string tag);
        int lat;
        @(negedge clk); win_addr = a; win_req = 1'b1;
        @(negedge clk);
        chk(pins() == ep, {tag, " pins"}, 32'(pins()), 32'(ep));
        if (ep != 4'b0111) begin
            chk(sd_addr == ea, {tag, " addr"}, 32'(sd_addr), 32'(ea));
            chk(sd_ba == eb, {tag, " bank"}, 32'(sd_ba), 32'(eb));
        end
        lat = 1;
        while (!win_ready && lat < 40) begin
            @(negedge clk); lat++;
            if (!win_ready) chk(pins() == 4'b0111, {tag, " nop in gap"},
                                32'(pins()), 32'h7);
        end
        chk(lat == elat, {tag, " ready latency"}, 32'(lat), 32'(elat));
        win_req = 1'b0;
        @(negedge clk);
        chk(!win_ready, {tag, " ready pulse"}, 32'(win_ready), 0);
    endtask

    task automatic t_reset();
        chk(reg_rdata == 0, "R1 reg", reg_rdata, 0);
        chk(!sd_clk_en && !win_ready, "R1 clk/ready", {sd_clk_en, win_ready}, 0);
        chk(pins() == 4'b0111 && sd_addr == 0 && sd_ba == 0, "R1 pins",
            {pins(), sd_addr, sd_ba}, 32'h7 << 15);
    endtask

    task automatic t_layout();
        wr_reg(32'hFFFF_FFFF);
        chk(reg_rdata == 32'h17, "R2 write all ones", reg_rdata, 32'h17);
        chk(sd_clk_en, "R3 clock on", 32'(sd_clk_en), 1);
        wr_reg(32'h0);
        chk(reg_rdata == 0, "R2 clear", reg_rdata, 0);
        chk(!sd_clk_en, "R3 clock off", 32'(sd_clk_en), 0);
    endtask

    task automatic t_drops();
        wr_reg(32'h07);
        win_write(16'h0442, 4'b0111, 0, 0, 1, "R11 disabled drop");
        chk(reg_rdata == 32'h07, "R11 arms kept", reg_rdata, 32'h07);
        wr_reg(32'h10);
        win_write(16'h0000, 4'b0111, 0, 0, 1, "R11 unarmed drop");
        chk(reg_rdata[3] == 0, "R9 flag before MRS", 32'(reg_rdata[3]), 0);
    endtask

    task automatic t_pall_ref();
        wr_reg(32'h12);
        win_write(16'h0000, 4'b0010, 13'h400, 0, 4, "R4 R8 PALL");
        chk(reg_rdata == 32'h10, "R7 PALL arm cleared", reg_rdata, 32'h10);
        wr_reg(32'h11);
        win_write(16'h0000, 4'b0001, 13'h000, 0, 8, "R4 R8 REF");
        chk(reg_rdata == 32'h10, "R7 REF arm cleared", reg_rdata, 32'h10);
        win_write(16'h0000, 4'b0111, 0, 0, 1, "R7 no rearm");
    endtask

    task automatic t_priority();
        cas_cfg = 2'd2;
        wr_reg(32'h17);
        win_write(16'h0442, 4'b0000, 13'h221, 2'd0, 3, "R6 R5 MRS first");
        chk(reg_rdata == 32'h1B, "R9 flag set, MRS arm cleared", reg_rdata, 32'h1B);
        chk(!cl_err, "R10 match", 32'(cl_err), 0);
        win_write(16'h0000, 4'b0010, 13'h400, 0, 4, "R6 PALL second");
        chk(reg_rdata == 32'h19, "R6 after PALL", reg_rdata, 32'h19);
        win_write(16'h0000, 4'b0001, 13'h000, 0, 8, "R6 REF third");
        chk(reg_rdata == 32'h18, "R6 after REF", reg_rdata, 32'h18);
    endtask

    task automatic t_mismatch();
        cas_cfg = 2'd3;
        wr_reg(32'h14);
        win_write(16'hC442, 4'b0000, 13'h221, 2'd3, 3, "R5 MRS bank");
        chk(cl_err, "R10 mismatch", 32'(cl_err), 1);
        wr_reg(32'h08);
        chk(reg_rdata == 32'h08, "R2 R9 flag read-only", reg_rdata, 32'h08);
        wr_reg(32'h14);
        win_write(16'h0060, 4'b0000, 13'h030, 2'd0, 3, "R5 MRS CL3");
        chk(!cl_err, "R10 match CL3", 32'(cl_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_layout();
        t_drops();
        t_pall_ref();
        t_priority();
        t_mismatch();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule